// File: doc/BRIEF.md
# STOP Mode Oscillator Warm-up Controller

This block controls a low-power halt of a small clock subsystem. When software pulses a request while the system is running, the block drops both the oscillator enable and the system-clock enable and waits for an interrupt. Once an interrupt is pending, the oscillator is enabled again. A counter, clocked by the oscillator, then holds the system clock off for a programmable settling interval before the clock is released.

The interval is chosen by a 2-bit code that is captured at the moment of the halt request. Code 01 selects 2^8 oscillator cycles, code 10 selects 2^14 and code 11 selects 2^16. With a 10 MHz oscillator these come to 25.6 us, 1.638 ms and 6.554 ms. Code 00 is reserved and is handled as the longest interval. If an interrupt is already pending when the request arrives, the oscillator is never stopped and the settling interval starts at once.

The machine has three states. RUN has the oscillator and the clock on. HALT has both off. WARM has the oscillator on and the clock off. The transitions are:
- RUN to HALT on a request with no interrupt pending.
- RUN to WARM on a request with an interrupt pending.
- HALT to WARM on an interrupt.
- WARM to RUN at the terminal count.
- Any state to RUN on synchronous reset.

Top module: `stop_wu_ctrl`

## Requirements
- R1: After synchronous reset the block is running: osc_en=1, sysclk_en=1, halted=0.
- R2: A stop_req sampled in the running state while irq_pend=0 gives osc_en=0, sysclk_en=0 and halted=1 on the next cycle.
- R3: While halted with the oscillator off and irq_pend=0, osc_en and sysclk_en stay 0 for as long as that lasts.
- R4: irq_pend=1 sampled while the oscillator is off gives osc_en=1 on the next cycle, with sysclk_en still 0.
- R5: The warm-up interval is N cycles. These are the cycles that have osc_en=1 and sysclk_en=0, counted from the first cycle with the oscillator back on, with the count starting at zero. sysclk_en rises on the cycle after the terminal count. N is 2^8 for code 01, 2^14 for code 10 and 2^16 for code 11.
- R6: The reserved code 00 gives N=2^16.
- R7: The code is captured in the cycle stop_req is accepted. Changes to wup_sel after that do not alter the interval of the wake-up that follows.
- R8: If irq_pend=1 in the cycle stop_req is accepted, osc_en stays 1, and sysclk_en goes 0 for exactly N cycles before returning to 1.
- R9: halted is 1 from the cycle after the accepted request until the cycle sysclk_en returns to 1, and it falls in that same cycle.
- R10: stop_req while halted or warming up has no effect: the oscillator stays off, or the warm-up length is unchanged.
- R11: Synchronous reset during the halt or during warm-up returns the block to the running state on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Halt request strobe |
| irq_pend | input | 1 | An enabled interrupt is pending |
| wup_sel | input | 2 | Warm-up interval code |
| osc_en | output | 1 | Oscillator enable |
| sysclk_en | output | 1 | System clock enable |
| halted | output | 1 | Halt or warm-up in progress |

## Verification
Two events can fall in the same cycle: the halt request and the arrival of the wake-up interrupt. The bench provokes this by driving stop_req and irq_pend together. It then judges that osc_en never drops while the clock stays off for exactly the selected count. A second collision is a fresh stop_req arriving during warm-up. For that case the bench checks that the interval still ends on the originally predicted cycle and that the captured code is the one left in force.

// File: rtl/stop_wu_pkg.sv
package stop_wu_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WARM = 2'd2
    } wu_state_t;

    localparam logic [1:0] CODE_RSVD  = 2'b00;
    localparam logic [1:0] CODE_SHORT = 2'b01;
    localparam logic [1:0] CODE_MID   = 2'b10;
    localparam logic [1:0] CODE_LONG  = 2'b11;
endpackage

// File: rtl/wu_timer.sv
module wu_timer #(
    parameter int SHORT_EXP = 8,
    parameter int MID_EXP   = 14,
    parameter int LONG_EXP  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       warm,
    input  logic [1:0] code,
    output logic       done
);
    import stop_wu_pkg::*;

    localparam int CW = LONG_EXP;
    localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

    logic [CW-1:0] cnt;
    logic [CW-1:0] term;

    always_comb begin
        unique case (code)
            CODE_SHORT: term = ALL1 >> (CW - SHORT_EXP);
            CODE_MID:   term = ALL1 >> (CW - MID_EXP);
            default:    term = ALL1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !warm) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign done = warm && (cnt == term);

    // R5: count never passes the terminal value
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        warm |-> (cnt <= term));
    // R5: the count starts from zero on the first warm-up cycle
    a_r5_start_zero: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(warm)) |-> (cnt == '0));
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       irq_pend,
    input  logic [1:0] wup_sel,
    input  logic       done,
    output logic [1:0] code_q,
    output logic       warm,
    output logic       osc_en,
    output logic       sysclk_en,
    output logic       halted
);
    import stop_wu_pkg::*;

    wu_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (stop_req) nxt = irq_pend ? ST_WARM : ST_HALT;
            ST_HALT: if (irq_pend) nxt = ST_WARM;
            ST_WARM: if (done)     nxt = ST_RUN;
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            code_q <= CODE_LONG;
        end else begin
            state <= nxt;
            if (state == ST_RUN && stop_req) code_q <= wup_sel;
        end
    end

    always_comb begin
        osc_en    = 1'b1;
        sysclk_en = 1'b0;
        halted    = 1'b1;
        warm      = 1'b0;
        unique case (state)
            ST_RUN:  begin sysclk_en = 1'b1; halted = 1'b0; end
            ST_HALT: osc_en = 1'b0;
            ST_WARM: warm = 1'b1;
            default: begin sysclk_en = 1'b1; halted = 1'b0; end
        endcase
    end

    // R1, R11: reset leaves the block running
    a_r11_reset_runs: assert property (@(posedge clk)
        rst |=> (osc_en && sysclk_en && !halted));
    // R2: request with no interrupt stops oscillator and clock
    a_r2_enter_halt: assert property (@(posedge clk) disable iff (rst)
        (sysclk_en && stop_req && !irq_pend) |=> (!osc_en && !sysclk_en && halted));
    // R4: interrupt while halted restarts the oscillator only
    a_r4_wake: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && irq_pend) |=> (osc_en && !sysclk_en));
    // R8: pending interrupt at request keeps the oscillator running
    a_r8_no_osc_drop: assert property (@(posedge clk) disable iff (rst)
        (sysclk_en && stop_req && irq_pend) |=> (osc_en && !sysclk_en));
    // R7: captured code is frozen during halt and warm-up
    a_r7_code_frozen: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> $stable(code_q));
    // R9: status falls exactly when the clock returns
    a_r9_status_clk: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> $rose(sysclk_en));
endmodule

// File: rtl/stop_wu_ctrl.sv
module stop_wu_ctrl #(
    parameter int SHORT_EXP = 8,
    parameter int MID_EXP   = 14,
    parameter int LONG_EXP  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       irq_pend,
    input  logic [1:0] wup_sel,
    output logic       osc_en,
    output logic       sysclk_en,
    output logic       halted
);
    logic [1:0] code_q;
    logic       warm;
    logic       done;

    stop_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (stop_req),
        .irq_pend  (irq_pend),
        .wup_sel   (wup_sel),
        .done      (done),
        .code_q    (code_q),
        .warm      (warm),
        .osc_en    (osc_en),
        .sysclk_en (sysclk_en),
        .halted    (halted)
    );

    wu_timer #(
        .SHORT_EXP (SHORT_EXP),
        .MID_EXP   (MID_EXP),
        .LONG_EXP  (LONG_EXP)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .warm (warm),
        .code (code_q),
        .done (done)
    );
endmodule

// File: tb/test_stop_wu_ctrl.sv
module test_stop_wu_ctrl;
    logic clk = 1'b0;
    logic rst, stop_req, irq_pend;
    logic [1:0] wup_sel;
    logic osc_en, sysclk_en, halted;
    int total = 0;
    int bad = 0;
    bit timed_out = 1'b0;

    always #2 clk = ~clk;

    stop_wu_ctrl i_stop_wu_ctrl (
        .clk(clk), .rst(rst), .stop_req(stop_req), .irq_pend(irq_pend),
        .wup_sel(wup_sel), .osc_en(osc_en), .sysclk_en(sysclk_en), .halted(halted)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int span(input logic [1:0] c);
        case (c)
            2'b01:   return 256;
            2'b10:   return 16384;
            default: return 65536;
        endcase
    endfunction

    // count negedge samples with osc on and clock off; the current sample is the first
    task automatic count_warm(output int n);
        n = 0;
        while (!sysclk_en && n < 70000) begin
            if (osc_en) n++;
            @(negedge clk);
        end
    endtask

    task automatic request(input logic [1:0] c, input logic irq_now);
        @(negedge clk);
        stop_req = 1'b1; wup_sel = c; irq_pend = irq_now;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic wake;
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; stop_req = 1'b0; irq_pend = 1'b0; wup_sel = 2'b01;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 osc_en", osc_en, 1);
        check("R1 sysclk_en", sysclk_en, 1);
        check("R1 halted", halted, 0);
    endtask

    task automatic t_halt_and_wake;
        int n;
        request(2'b01, 1'b0);
        check("R2 osc_en", osc_en, 0);
        check("R2 sysclk_en", sysclk_en, 0);
        check("R2 halted", halted, 1);
        repeat (20) @(negedge clk);
        check("R3 osc_en stays off", osc_en, 0);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        @(negedge clk);
        check("R10 halt osc_en", osc_en, 0);
        check("R10 halt sysclk_en", sysclk_en, 0);
        wake;
        check("R4 osc_en", osc_en, 1);
        check("R4 sysclk_en", sysclk_en, 0);
        check("R9 halted in warm", halted, 1);
        count_warm(n);
        check("R5 code01 length", n, 256);
        check("R9 halted cleared", halted, 0);
    endtask

    task automatic t_code(input logic [1:0] c, input string req);
        int n;
        request(c, 1'b0);
        repeat (4) @(negedge clk);
        wake;
        count_warm(n);
        check(req, n, span(c));
    endtask

    task automatic t_capture;
        int n;
        request(2'b01, 1'b0);
        wup_sel = 2'b11;
        repeat (5) @(negedge clk);
        wake;
        count_warm(n);
        check("R7 code captured at request", n, 256);
    endtask

    task automatic t_same_cycle;
        int n;
        request(2'b01, 1'b1);
        irq_pend = 1'b0;
        check("R8 osc_en kept", osc_en, 1);
        check("R8 sysclk_en off", sysclk_en, 0);
        count_warm(n);
        check("R8 length", n, 256);
    endtask

    task automatic t_req_in_warm;
        int n;
        request(2'b01, 1'b0);
        wake;
        n = 0;
        repeat (10) begin if (osc_en && !sysclk_en) n++; @(negedge clk); end
        stop_req = 1'b1; wup_sel = 2'b11;
        if (osc_en && !sysclk_en) n++;
        @(negedge clk);
        stop_req = 1'b0;
        begin
            int m;
            count_warm(m);
            check("R10 warm length unchanged", n + m, 256);
        end
    endtask

    task automatic t_reset_mid;
        request(2'b01, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset in halt sysclk_en", sysclk_en, 1);
        check("R11 reset in halt halted", halted, 0);
        request(2'b01, 1'b0);
        wake;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset in warm sysclk_en", sysclk_en, 1);
        check("R11 reset in warm osc_en", osc_en, 1);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        timed_out = 1'b1;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset;
        t_halt_and_wake;
        t_code(2'b10, "R5 code10 length");
        t_code(2'b11, "R5 code11 length");
        t_code(2'b00, "R6 reserved code length");
        t_capture;
        t_same_cycle;
        t_req_in_warm;
        t_reset_mid;
        if (!timed_out) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule